// File: doc/BRIEF.md
# Load-and-Issue Operand Mover

A small two-stage processor that moves neural-network operand data from main memory into the buffers of accelerator processing engines (PEs). A fetch stage reads 32-bit instruction words from an instruction port and holds each word in a register. A decode stage takes a word from that register only when it is free to accept one. The decode stage recognises two operations. A load reads one memory word over a read bus into a register of a 32-entry register file. An issue writes one register value over a separate write bus into a PE buffer. Both operations form their address as a register plus a sign-extended immediate.

A load retires from decode once its read request is accepted. At most one read may then be outstanding. Later issues that do not touch the pending destination register proceed on the write bus while the read data is still in flight, so the two buses can overlap. An issue that reads the pending register waits until the returned word has been written. Every other opcode retires at once as a no-op and raises a one-cycle illegal flag. A one-bit output shows the kind of the last load or issue.

Top module: `operand_mover`

## Requirements
- R1: While rst_ni is low and in the first cycle after reset, imem_addr_o is 0, rd_valid_o and wr_valid_o are 0, and op_kind_o is 0.
- R2: Instruction words are fetched from consecutive byte addresses 0, 4, 8 and so on, and are executed in fetch order. imem_addr_o advances by 4 only in a cycle where imem_req_o and imem_valid_i are both high, and it does not move while decode is stalled with the fetch register full.
- R3: A word with bits [6:0] = 7'b0001111 is a load. The destination register is bits [11:7] and the base register is bits [19:15]. The offset is bits [31:20], sign-extended. rd_addr_o = x[base] + offset, and the returned rd_rdata_i is written into the destination register.
- R4: A word with bits [6:0] = 7'b0100111 is an issue. The source register is bits [24:20] and the base register is bits [19:15]. The offset is {bits[31:25], bits[11:7]}, sign-extended. wr_addr_o = x[base] + offset and wr_data_o = x[source].
- R5: op_kind_o becomes 0 in the cycle after a read request is accepted (rd_valid_o and rd_ready_i both high), and becomes 1 in the cycle after a write is accepted (wr_valid_o and wr_ready_i both high).
- R6: Register x0 always reads as zero, and a load with destination x0 leaves it zero.
- R7: rd_valid_o and rd_addr_o hold steady until rd_ready_i is seen. No new read request is raised while an earlier read has not yet returned data on rd_rvalid_i.
- R8: wr_valid_o, wr_addr_o and wr_data_o hold steady until wr_ready_i is seen.
- R9: Any other opcode retires in one cycle with illegal_o high for that cycle. It causes no bus request and leaves op_kind_o unchanged.
- R10: An issue whose source or base register is the destination of a pending load waits. It writes the returned value, not the old one.
- R11: An issue that does not depend on the pending load may be accepted on the write bus while that load's data has not yet returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| imem_req_o | output | 1 | Fetch register can take a word this cycle |
| imem_addr_o | output | AW | Byte address of the next instruction word |
| imem_valid_i | input | 1 | imem_data_i holds the word at imem_addr_o |
| imem_data_i | input | 32 | Instruction word |
| rd_valid_o | output | 1 | Read request valid |
| rd_ready_i | input | 1 | Read request accepted |
| rd_addr_o | output | AW | Read address |
| rd_rvalid_i | input | 1 | Read data returned this cycle |
| rd_rdata_i | input | XLEN | Read data |
| wr_valid_o | output | 1 | PE buffer write valid |
| wr_ready_i | input | 1 | PE buffer write accepted |
| wr_addr_o | output | AW | PE buffer address |
| wr_data_o | output | XLEN | PE buffer data |
| op_kind_o | output | 1 | Last retired transfer: 0 load, 1 issue |
| illegal_o | output | 1 | Unknown opcode retiring this cycle |

## Verification
The properties check the bus-level rules on every cycle: request hold on both buses, at most one outstanding read, the flag values after each accepted transfer, the quiet buses and steady flag on an illegal opcode, and the 4-byte fetch step. The register-level results can only be shown by the bench's scenarios. These are the addresses and data computed from register contents, x0 staying zero, the stall of a dependent issue until load data lands, and overlap of independent issues with a pending read. The bench checks them by comparing every bus transfer in order against a reference walk of the program.

// File: rtl/om_pkg.sv
package om_pkg;
  localparam int unsigned ILEN = 32;
  localparam logic [6:0] OPC_LOAD  = 7'b0001111;
  localparam logic [6:0] OPC_ISSUE = 7'b0100111;

  function automatic logic [11:0] imm_ld(input logic [ILEN-1:0] w);
    return w[31:20];
  endfunction

  function automatic logic [11:0] imm_is(input logic [ILEN-1:0] w);
    return {w[31:25], w[11:7]};
  endfunction
endpackage

// File: rtl/om_fetch.sv
module om_fetch
  import om_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic            imem_req_o,
  output logic [AW-1:0]   imem_addr_o,
  input  logic            imem_valid_i,
  input  logic [ILEN-1:0] imem_data_i,
  output logic            out_valid_o,
  output logic [ILEN-1:0] out_instr_o,
  input  logic            out_ready_i
);
  localparam logic [AW-1:0] STEP = AW'(ILEN / 8);

  logic            valid_q;
  logic [ILEN-1:0] instr_q;
  logic [AW-1:0]   pc_q;
  logic            take;

  assign imem_req_o  = !valid_q || out_ready_i;
  assign take        = imem_req_o && imem_valid_i;
  assign imem_addr_o = pc_q;
  assign out_valid_o = valid_q;
  assign out_instr_o = instr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      instr_q <= '0;
      pc_q    <= '0;
    end else begin
      if (imem_req_o) valid_q <= imem_valid_i;
      if (take) begin
        instr_q <= imem_data_i;
        pc_q    <= pc_q + STEP;
      end
    end
  end
endmodule

// File: rtl/om_regfile.sv
module om_regfile #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned NREG = 32,
  localparam int unsigned RIDX = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [RIDX-1:0] ra_idx_i,
  output logic [XLEN-1:0] ra_data_o,
  input  logic [RIDX-1:0] rb_idx_i,
  output logic [XLEN-1:0] rb_data_o,
  input  logic            we_i,
  input  logic [RIDX-1:0] waddr_i,
  input  logic [XLEN-1:0] wdata_i
);
  logic [XLEN-1:0] regs [NREG];

  for (genvar k = 0; k < NREG; k++) begin : g_ent
    if (k == 0) begin : g_zero
      assign regs[k] = '0;
    end else begin : g_reg
      logic [XLEN-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                               q <= '0;
        else if (we_i && waddr_i == RIDX'(k))      q <= wdata_i;
      end
      assign regs[k] = q;
    end
  end

  assign ra_data_o = regs[ra_idx_i];
  assign rb_data_o = regs[rb_idx_i];
endmodule

// File: rtl/om_decode.sv
module om_decode
  import om_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned AW   = 32,
  parameter int unsigned NREG = 32,
  localparam int unsigned RIDX = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            in_valid_i,
  input  logic [ILEN-1:0] in_instr_i,
  output logic            in_ready_o,
  output logic [RIDX-1:0] rs1_idx_o,
  output logic [RIDX-1:0] rs2_idx_o,
  input  logic [XLEN-1:0] rs1_data_i,
  input  logic [XLEN-1:0] rs2_data_i,
  output logic            rf_we_o,
  output logic [RIDX-1:0] rf_waddr_o,
  output logic [XLEN-1:0] rf_wdata_o,
  output logic            rd_valid_o,
  input  logic            rd_ready_i,
  output logic [AW-1:0]   rd_addr_o,
  input  logic            rd_rvalid_i,
  input  logic [XLEN-1:0] rd_rdata_i,
  output logic            wr_valid_o,
  input  logic            wr_ready_i,
  output logic [AW-1:0]   wr_addr_o,
  output logic [XLEN-1:0] wr_data_o,
  output logic            op_kind_o,
  output logic            illegal_o
);
  logic            id_valid_q;
  logic [ILEN-1:0] id_instr_q;
  logic            pend_q;
  logic [RIDX-1:0] pend_rd_q;
  logic            kind_q;

  logic            is_load, is_issue, raw;
  logic            rd_fire, wr_fire, retire;
  logic [RIDX-1:0] dst_idx;
  logic [11:0]     off_ld, off_is;
  logic [XLEN-1:0] ea_ld, ea_is;

  assign is_load   = id_instr_q[6:0] == OPC_LOAD;
  assign is_issue  = id_instr_q[6:0] == OPC_ISSUE;
  assign rs1_idx_o = id_instr_q[15 +: RIDX];
  assign rs2_idx_o = id_instr_q[20 +: RIDX];
  assign dst_idx   = id_instr_q[7 +: RIDX];
  assign off_ld    = imm_ld(id_instr_q);
  assign off_is    = imm_is(id_instr_q);
  assign ea_ld     = rs1_data_i + {{(XLEN-12){off_ld[11]}}, off_ld};
  assign ea_is     = rs1_data_i + {{(XLEN-12){off_is[11]}}, off_is};

  // dependent issue waits for the pending load to land; x0 never pends
  assign raw = pend_q && (pend_rd_q != '0) &&
               (rs1_idx_o == pend_rd_q || rs2_idx_o == pend_rd_q);

  assign rd_valid_o = id_valid_q && is_load && !pend_q;
  assign wr_valid_o = id_valid_q && is_issue && !raw;
  assign illegal_o  = id_valid_q && !is_load && !is_issue;
  assign rd_addr_o  = ea_ld[AW-1:0];
  assign wr_addr_o  = ea_is[AW-1:0];
  assign wr_data_o  = rs2_data_i;

  assign rd_fire    = rd_valid_o && rd_ready_i;
  assign wr_fire    = wr_valid_o && wr_ready_i;
  assign retire     = rd_fire || wr_fire || illegal_o;
  assign in_ready_o = !id_valid_q || retire;

  assign rf_we_o    = pend_q && rd_rvalid_i;
  assign rf_waddr_o = pend_rd_q;
  assign rf_wdata_o = rd_rdata_i;
  assign op_kind_o  = kind_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      id_valid_q <= 1'b0;
      id_instr_q <= '0;
      pend_q     <= 1'b0;
      pend_rd_q  <= '0;
      kind_q     <= 1'b0;
    end else begin
      if (in_ready_o) begin
        id_valid_q <= in_valid_i;
        if (in_valid_i) id_instr_q <= in_instr_i;
      end
      if (rd_fire) begin
        pend_q    <= 1'b1;
        pend_rd_q <= dst_idx;
      end else if (rd_rvalid_i) begin
        pend_q    <= 1'b0;
      end
      if (rd_fire)      kind_q <= 1'b0;
      else if (wr_fire) kind_q <= 1'b1;
    end
  end
endmodule

// File: rtl/operand_mover.sv
module operand_mover
  import om_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned AW   = 32,
  parameter int unsigned NREG = 32,
  localparam int unsigned RIDX = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic            imem_req_o,
  output logic [AW-1:0]   imem_addr_o,
  input  logic            imem_valid_i,
  input  logic [31:0]     imem_data_i,
  output logic            rd_valid_o,
  input  logic            rd_ready_i,
  output logic [AW-1:0]   rd_addr_o,
  input  logic            rd_rvalid_i,
  input  logic [XLEN-1:0] rd_rdata_i,
  output logic            wr_valid_o,
  input  logic            wr_ready_i,
  output logic [AW-1:0]   wr_addr_o,
  output logic [XLEN-1:0] wr_data_o,
  output logic            op_kind_o,
  output logic            illegal_o
);
  logic            f_valid, d_ready;
  logic [ILEN-1:0] f_instr;
  logic [RIDX-1:0] rs1_idx, rs2_idx, w_idx;
  logic [XLEN-1:0] rs1_data, rs2_data, w_data;
  logic            w_en;

  om_fetch #(.AW(AW)) u_fetch (
    .clk_i, .rst_ni,
    .imem_req_o, .imem_addr_o, .imem_valid_i, .imem_data_i,
    .out_valid_o (f_valid),
    .out_instr_o (f_instr),
    .out_ready_i (d_ready)
  );

  om_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk_i, .rst_ni,
    .ra_idx_i  (rs1_idx), .ra_data_o (rs1_data),
    .rb_idx_i  (rs2_idx), .rb_data_o (rs2_data),
    .we_i      (w_en),    .waddr_i   (w_idx), .wdata_i (w_data)
  );

  om_decode #(.XLEN(XLEN), .AW(AW), .NREG(NREG)) u_dec (
    .clk_i, .rst_ni,
    .in_valid_i (f_valid), .in_instr_i (f_instr), .in_ready_o (d_ready),
    .rs1_idx_o  (rs1_idx), .rs2_idx_o  (rs2_idx),
    .rs1_data_i (rs1_data), .rs2_data_i (rs2_data),
    .rf_we_o    (w_en), .rf_waddr_o (w_idx), .rf_wdata_o (w_data),
    .rd_valid_o, .rd_ready_i, .rd_addr_o, .rd_rvalid_i, .rd_rdata_i,
    .wr_valid_o, .wr_ready_i, .wr_addr_o, .wr_data_o,
    .op_kind_o, .illegal_o
  );
endmodule

// File: rtl/om_checker.sv
module om_checker #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned AW   = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            imem_req_o,
  input logic [AW-1:0]   imem_addr_o,
  input logic            imem_valid_i,
  input logic            rd_valid_o,
  input logic            rd_ready_i,
  input logic [AW-1:0]   rd_addr_o,
  input logic            rd_rvalid_i,
  input logic            wr_valid_o,
  input logic            wr_ready_i,
  input logic [AW-1:0]   wr_addr_o,
  input logic [XLEN-1:0] wr_data_o,
  input logic            op_kind_o,
  input logic            illegal_o
);
  logic out_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    out_q <= 1'b0;
    else if (rd_valid_o && rd_ready_i) out_q <= 1'b1;
    else if (rd_rvalid_i)           out_q <= 1'b0;
  end

  assert_pc_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(imem_addr_o) |-> imem_addr_o == $past(imem_addr_o) + AW'(4) && $past(imem_req_o && imem_valid_i));
  assert_flag_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o && rd_ready_i |=> !op_kind_o);
  assert_flag_issue_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o && wr_ready_i |=> op_kind_o);
  assert_rd_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o && !rd_ready_i |=> rd_valid_o && $stable(rd_addr_o));
  assert_single_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> !out_q);
  assert_wr_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o && !wr_ready_i |=> wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o));
  assert_illegal_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !rd_valid_o && !wr_valid_o);
  assert_illegal_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |=> $stable(op_kind_o));
endmodule

bind operand_mover om_checker #(.XLEN(XLEN), .AW(AW)) u_chk (
  .clk_i, .rst_ni, .imem_req_o, .imem_addr_o, .imem_valid_i,
  .rd_valid_o, .rd_ready_i, .rd_addr_o, .rd_rvalid_i,
  .wr_valid_o, .wr_ready_i, .wr_addr_o, .wr_data_o,
  .op_kind_o, .illegal_o
);

// File: tb/operand_mover_test.sv
`timescale 1ns/1ps
module operand_mover_test;
  localparam int NPROG = 200;
  localparam int LIMIT = 20000;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        imem_req_o, imem_valid_i = 1'b0;
  logic [31:0] imem_addr_o, imem_data_i;
  logic        rd_valid_o, rd_ready_i = 1'b0, rd_rvalid_i = 1'b0;
  logic [31:0] rd_addr_o, rd_rdata_i = '0;
  logic        wr_valid_o, wr_ready_i = 1'b0;
  logic [31:0] wr_addr_o, wr_data_o;
  logic        op_kind_o, illegal_o;

  always #2.5 clk_i = ~clk_i;

  operand_mover uut (.*);

  logic [31:0] prog [NPROG];
  logic [31:0] exp_rd [NPROG];
  logic [31:0] exp_wa [NPROG];
  logic [31:0] exp_wd [NPROG];
  int n_rd, n_wr, n_ill;
  int checks = 0, fails = 0;

  assign imem_data_i = prog[imem_addr_o[9:2] < 8'(NPROG) ? imem_addr_o[9:2] : 8'd0];

  function automatic logic [31:0] mdat(input logic [31:0] a);
    return {a[15:0], a[31:16]} ^ 32'h5A3C_96E1;
  endfunction
  function automatic logic [31:0] enc_ld(input int rd, input int rs1, input logic [11:0] imm);
    return {imm, 5'(rs1), 3'b010, 5'(rd), 7'b0001111};
  endfunction
  function automatic logic [31:0] enc_is(input int rs2, input int rs1, input logic [11:0] imm);
    return {imm[11:5], 5'(rs2), 5'(rs1), 3'b010, imm[4:0], 7'b0100111};
  endfunction
  function automatic logic [31:0] sx(input logic [11:0] v);
    return {{20{v[11]}}, v};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // reference walk of the program in order
  task automatic build();
    logic [31:0] x [32];
    logic [31:0] w;
    logic [31:0] a;
    int r;
    void'($urandom(32'd7741));
    for (int k = 0; k < 32; k++) x[k] = '0;
    prog[0] = enc_ld(1, 0, 12'h100);
    prog[1] = enc_is(1, 0, 12'h020);   // R10 dependent on x1
    prog[2] = enc_ld(0, 0, 12'h044);   // R6 write to x0
    prog[3] = enc_is(0, 1, 12'hFFC);   // R6 read x0, negative offset
    prog[4] = 32'h0000_0033;           // R9 unknown opcode
    prog[5] = enc_ld(2, 1, 12'hFF8);
    prog[6] = enc_ld(3, 0, 12'h7FF);
    prog[7] = enc_is(3, 2, 12'h800);   // R10 via rs2, R4 min offset
    prog[8] = enc_ld(4, 0, 12'h010);
    prog[9] = enc_is(1, 0, 12'h005);   // R11 independent of x4
    for (int i = 10; i < NPROG; i++) begin
      r = $urandom % 10;
      if (r < 5)      prog[i] = enc_ld($urandom % 8, $urandom % 8, 12'($urandom));
      else if (r < 9) prog[i] = enc_is($urandom % 8, $urandom % 8, 12'($urandom));
      else            prog[i] = {25'($urandom), 7'b1110011};
    end
    n_rd = 0; n_wr = 0; n_ill = 0;
    for (int i = 0; i < NPROG; i++) begin
      w = prog[i];
      if (w[6:0] == 7'b0001111) begin
        a = x[w[19:15]] + sx(w[31:20]);
        exp_rd[n_rd++] = a;
        if (w[11:7] != 0) x[w[11:7]] = mdat(a);
      end else if (w[6:0] == 7'b0100111) begin
        exp_wa[n_wr] = x[w[19:15]] + sx({w[31:25], w[11:7]});
        exp_wd[n_wr++] = x[w[24:20]];
      end else n_ill++;
    end
  endtask

  initial begin
    int rd_seen = 0, wr_seen = 0, ill_seen = 0, overlaps = 0, idle = 0, cyc = 0;
    bit pend = 0, flag_chk = 0, exp_flag = 0, done = 0;
    logic [31:0] pend_addr = '0;
    int dly = 0;
    build();
    repeat (3) @(negedge clk_i);
    chk(imem_addr_o == 0 && !rd_valid_o && !wr_valid_o && !op_kind_o, "R1 in reset",
        {imem_addr_o[28:0], rd_valid_o, wr_valid_o, op_kind_o}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(imem_addr_o == 0 && !rd_valid_o && !wr_valid_o && !op_kind_o, "R1 after reset",
        {imem_addr_o[28:0], rd_valid_o, wr_valid_o, op_kind_o}, 32'h0);
    while (!done && cyc < LIMIT) begin
      @(negedge clk_i);
      cyc++;
      if (flag_chk) begin
        chk(op_kind_o == exp_flag, "R5 op flag", 32'(op_kind_o), 32'(exp_flag));
        flag_chk = 0;
      end
      if (rd_rvalid_i) begin rd_rvalid_i = 1'b0; pend = 0; end
      if (pend) begin
        if (dly == 0) begin rd_rvalid_i = 1'b1; rd_rdata_i = mdat(pend_addr); end
        else dly--;
      end
      rd_ready_i   = ($urandom % 4) != 0;
      wr_ready_i   = ($urandom % 3) != 0;
      imem_valid_i = (imem_addr_o[31:2] < NPROG) && (($urandom % 5) != 0);
      #1;
      if (rd_valid_o && rd_ready_i) begin
        chk(!pend, "R7 second read while pending", 32'(pend), 32'h0);
        if (rd_seen < n_rd) chk(rd_addr_o == exp_rd[rd_seen], "R3 read address", rd_addr_o, exp_rd[rd_seen]);
        else chk(0, "R3 extra read", rd_addr_o, 32'h0);
        rd_seen++;
        pend = 1; pend_addr = rd_addr_o; dly = $urandom % 6;
        exp_flag = 0; flag_chk = 1;
      end
      if (wr_valid_o && wr_ready_i) begin
        if (pend) overlaps++;
        if (wr_seen < n_wr) begin
          chk(wr_addr_o == exp_wa[wr_seen], "R4 write address", wr_addr_o, exp_wa[wr_seen]);
          chk(wr_data_o == exp_wd[wr_seen], "R4/R6/R10 write data", wr_data_o, exp_wd[wr_seen]);
        end else chk(0, "R4 extra write", wr_addr_o, 32'h0);
        wr_seen++;
        exp_flag = 1; flag_chk = 1;
      end
      if (illegal_o) begin
        ill_seen++;
        chk(op_kind_o == exp_flag && !rd_valid_o && !wr_valid_o, "R9 illegal quiet",
            {op_kind_o, rd_valid_o, wr_valid_o}, {2'b0, exp_flag});
      end
      if (rd_seen == n_rd && wr_seen == n_wr && !pend && imem_addr_o == 32'(NPROG * 4)) idle++;
      if (idle > 20) done = 1;
    end
    if (!done) chk(0, "watchdog", 32'(cyc), 32'(LIMIT));
    chk(imem_addr_o == 32'(NPROG * 4), "R2 fetch end address", imem_addr_o, 32'(NPROG * 4));
    chk(rd_seen == n_rd, "R3 read count", 32'(rd_seen), 32'(n_rd));
    chk(wr_seen == n_wr, "R4 write count", 32'(wr_seen), 32'(n_wr));
    chk(ill_seen == n_ill, "R9 illegal count", 32'(ill_seen), 32'(n_ill));
    chk(overlaps > 0, "R11 write during pending read", 32'(overlaps), 32'h1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule